// File: doc/BRIEF.md
# Ancillary Packet Deletion Filter

This block sits in a 10-bit video word path clocked by the pixel clock. It forwards every word to its output after a fixed delay. When deletion is switched on, it also blanks out whole ancillary data packets whose data identifier matches one of a small table of programmed identifiers. The table slots are audio, extended audio, arbitrary data and audio control. Packets that carry error-detection (EDH) data are never touched, even if a table slot holds their identifier. Blanking those other packets leaves the EDH checksums stale, and regenerating them is left to a later stage.

For composite video the same path can also blank timing reference sequences. Blanked words are written with blanking levels rather than dropped, so the line length and the latency do not change. A short delay line holds each packet header until its identifier and data count are known. After that point the decision for the whole packet is fixed.

Deletion turns on in either of two ways: a dedicated pin, or the pair of register bits "select" and "delete". Timing-reference removal likewise turns on through its own pin, or through "select" together with a TRS bit.

Top module: `anc_pkt_filter`

## Requirements
- R1: With deletion and TRS removal both off, every input word appears unchanged on `dout` exactly 7 clock edges after the edge that captures it.
- R2: Deletion is on when `anc_del_pin` is high, or when `reg_sel` and `reg_del` are both high. `reg_sel` alone, or `reg_del` alone, turns nothing on.
- R3: A packet starts with the header words 0x000, 0x3FF, 0x3FF. The identifier word follows, then one secondary-ID/block word, then the data-count word. The packet holds N data words, N being the low 8 bits of the data-count word, and ends with one checksum word, so it spans 7+N words. When deletion is on and the identifier's low 8 bits equal any of the four slots of `id_table` (slot i at bits 8i+7..8i), all 7+N words are replaced.
- R4: While deletion is on, a packet whose identifier matches no slot passes unchanged.
- R5: A packet whose identifier low byte is 0xF4 (EDH) always passes unchanged, even when a table slot holds 0xF4.
- R6: A replaced word is 0x100 when `comp_mode` is high. When `comp_mode` is low, replaced words alternate 0x200, 0x040, 0x200, ..., and the first word of every replaced region is 0x200.
- R7: With `comp_mode` high, a timing reference of the four words 0x3FF, 0x000, 0x000, XYZ is replaced when `trs_del_pin` is high, or when `reg_sel` and `reg_trs` are both high.
- R8: With `comp_mode` low, timing references always pass unchanged, whatever the TRS controls are.
- R9: Words after a replaced region pass unchanged. A packet that follows directly after a replaced one is judged on its own identifier.
- R10: The decision for a packet is taken when its header is complete. Changing the deletion controls after that point does not alter how that packet is treated.
- R11: During and directly after reset, `dout` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_mode | input | 1 | High for composite video, low for component |
| anc_del_pin | input | 1 | Pin-level packet deletion enable |
| trs_del_pin | input | 1 | Pin-level timing-reference removal enable |
| reg_sel | input | 1 | Register select: lets the register bits act |
| reg_del | input | 1 | Register packet deletion bit |
| reg_trs | input | 1 | Register timing-reference removal bit |
| id_table | input | NUM_IDS*8 | Identifier slots: audio, extended audio, arbitrary, audio control |
| din | input | W | Video word in |
| dout | output | W | Filtered video word out |

## Verification
The assertions assume a well-formed stream. Data, identifier and count words never take the reserved values 0x000 or 0x3FF, so a header pattern can only occur at a real packet or timing reference boundary. They also assume that `comp_mode` and `id_table` stay steady while a region is being replaced. The bench builds every stream from legal words only: idle fill 0x080, data words 0x100 plus an index, identifier words 0x100 with the identifier byte added, and a count word carrying bit 9 to show that only the low byte counts. It changes controls only between streams, except in the one scenario that moves the deletion pin after a header has been judged.

// File: rtl/anc_filt_pkg.sv
package anc_filt_pkg;

   // words from the first header word through the data-count word
   localparam int HDR_SPAN  = 6;
   // fixed words around the data payload: 3 header, id, block, count, checksum
   localparam int PKT_EXTRA = 7;
   // words in a timing reference
   localparam int TRS_SPAN  = 4;

   localparam logic [9:0] WORD_LO   = 10'h000;
   localparam logic [9:0] WORD_HI   = 10'h3FF;
   localparam logic [9:0] BLK_LUMA  = 10'h040;
   localparam logic [9:0] BLK_CHROM = 10'h200;
   localparam logic [9:0] BLK_COMP  = 10'h100;

   localparam logic [7:0] EDH_ID    = 8'hF4;

   typedef enum logic [1:0] {
      RGN_IDLE = 2'd0,
      RGN_ANC  = 2'd1,
      RGN_TRS  = 2'd2
   } rgn_e;

endpackage

// File: rtl/anc_delay_line.sv
module anc_delay_line #(
   parameter int W     = 10,
   parameter int DEPTH = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [W-1:0]       din,
   output logic [DEPTH*W-1:0] taps
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("anc_delay_line: DEPTH must be at least 1");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [W-1:0] q;
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[i-1].q;
         end
      end
      assign taps[i*W +: W] = q;
   end

endmodule

// File: rtl/anc_hdr_match.sv
module anc_hdr_match
   import anc_filt_pkg::*;
#(
   parameter int W       = 10,
   parameter int NUM_IDS = 4,
   parameter int ID_BITS = 8,
   parameter int DC_BITS = 8,
   parameter int DEPTH   = 6,
   parameter int LEN_W   = 9
) (
   input  logic [DEPTH*W-1:0]         taps,
   input  logic [NUM_IDS*ID_BITS-1:0] id_table,
   output logic                       anc_start,
   output logic                       trs_start,
   output logic                       is_edh,
   output logic                       id_hit,
   output logic [LEN_W-1:0]           pkt_len
);

   // tap positions, oldest word at DEPTH-1
   localparam int T_H0  = DEPTH - 1;
   localparam int T_H1  = DEPTH - 2;
   localparam int T_H2  = DEPTH - 3;
   localparam int T_ID  = DEPTH - 4;
   localparam int T_BLK = DEPTH - 5;
   localparam int T_DC  = DEPTH - 6;

   if (DEPTH != HDR_SPAN) begin : g_bad_depth
      $error("anc_hdr_match: DEPTH must equal the header span");
   end

   logic [W-1:0] w_h0, w_h1, w_h2, w_id, w_blk, w_dc;
   assign w_h0  = taps[T_H0*W  +: W];
   assign w_h1  = taps[T_H1*W  +: W];
   assign w_h2  = taps[T_H2*W  +: W];
   assign w_id  = taps[T_ID*W  +: W];
   assign w_blk = taps[T_BLK*W +: W];
   assign w_dc  = taps[T_DC*W  +: W];

   assign anc_start = (w_h0 == W'(WORD_LO)) && (w_h1 == W'(WORD_HI)) && (w_h2 == W'(WORD_HI));
   assign trs_start = (w_h0 == W'(WORD_HI)) && (w_h1 == W'(WORD_LO)) && (w_h2 == W'(WORD_LO));

   logic [ID_BITS-1:0] id_val;
   assign id_val = w_id[ID_BITS-1:0];
   assign is_edh = (id_val == ID_BITS'(EDH_ID));

   logic [NUM_IDS-1:0] slot_hit;
   for (genvar s = 0; s < NUM_IDS; s++) begin : g_slot
      assign slot_hit[s] = (id_val == id_table[s*ID_BITS +: ID_BITS]);
   end

   assign id_hit  = (|slot_hit) && !is_edh;
   assign pkt_len = LEN_W'(PKT_EXTRA) + LEN_W'(w_dc[DC_BITS-1:0]);

   logic unused_hdr;
   assign unused_hdr = ^{w_blk, w_dc, w_id};

endmodule

// File: rtl/anc_region_seq.sv
module anc_region_seq
   import anc_filt_pkg::*;
#(
   parameter int DC_BITS = 8,
   parameter int LEN_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             anc_go,
   input  logic             trs_go,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             rep,
   output logic             ph,
   output logic             busy
);

   localparam int MAX_LEFT = PKT_EXTRA + (1 << DC_BITS) - 2;

   rgn_e             kind;
   logic [LEN_W-1:0] left;
   logic             ph_q;

   assign busy = (kind != RGN_IDLE);
   assign rep  = busy || anc_go || trs_go;
   assign ph   = busy && ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind <= RGN_IDLE;
         left <= '0;
         ph_q <= 1'b0;
      end else if (busy) begin
         left <= left - LEN_W'(1);
         ph_q <= !ph_q;
         if (left == LEN_W'(1)) kind <= RGN_IDLE;
      end else if (anc_go) begin
         kind <= RGN_ANC;
         left <= pkt_len - LEN_W'(1);
         ph_q <= 1'b1;
      end else if (trs_go) begin
         kind <= RGN_TRS;
         left <= LEN_W'(TRS_SPAN - 1);
         ph_q <= 1'b1;
      end
   end

   // R3: a running packet region never holds more than a full packet
   assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (left != '0) && (left <= LEN_W'(MAX_LEFT)));

   // R7: a timing-reference region never runs longer than four words
   assert_trs_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == RGN_TRS) |-> (left < LEN_W'(TRS_SPAN)));

endmodule

// File: rtl/anc_pkt_filter.sv
module anc_pkt_filter
   import anc_filt_pkg::*;
#(
   parameter int W       = 10,
   parameter int NUM_IDS = 4,
   parameter int ID_BITS = 8,
   parameter int DC_BITS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       comp_mode,
   input  logic                       anc_del_pin,
   input  logic                       trs_del_pin,
   input  logic                       reg_sel,
   input  logic                       reg_del,
   input  logic                       reg_trs,
   input  logic [NUM_IDS*ID_BITS-1:0] id_table,
   input  logic [W-1:0]               din,
   output logic [W-1:0]               dout
);

   localparam int DEPTH = HDR_SPAN;
   localparam int LEN_W = DC_BITS + 1;

   if (W < 10) begin : g_bad_w
      $error("anc_pkt_filter: W must be at least 10");
   end
   if (ID_BITS < 8 || ID_BITS > W) begin : g_bad_id
      $error("anc_pkt_filter: ID_BITS must lie between 8 and W");
   end
   if (DC_BITS < 3 || DC_BITS > W) begin : g_bad_dc
      $error("anc_pkt_filter: DC_BITS must lie between 3 and W");
   end
   if (NUM_IDS < 1) begin : g_bad_n
      $error("anc_pkt_filter: NUM_IDS must be at least 1");
   end

   logic del_en, trs_en;
   assign del_en = anc_del_pin || (reg_sel && reg_del);
   assign trs_en = comp_mode && (trs_del_pin || (reg_sel && reg_trs));

   logic [DEPTH*W-1:0] taps;
   logic [W-1:0]       oldest;

   anc_delay_line #(.W(W), .DEPTH(DEPTH)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .taps  (taps)
   );

   assign oldest = taps[(DEPTH-1)*W +: W];

   logic             anc_start, trs_start, is_edh, id_hit;
   logic [LEN_W-1:0] pkt_len;

   anc_hdr_match #(
      .W(W), .NUM_IDS(NUM_IDS), .ID_BITS(ID_BITS),
      .DC_BITS(DC_BITS), .DEPTH(DEPTH), .LEN_W(LEN_W)
   ) u_hdr (
      .taps      (taps),
      .id_table  (id_table),
      .anc_start (anc_start),
      .trs_start (trs_start),
      .is_edh    (is_edh),
      .id_hit    (id_hit),
      .pkt_len   (pkt_len)
   );

   logic anc_go, trs_go, rep, ph, busy;
   assign anc_go = anc_start && id_hit && del_en;
   assign trs_go = trs_start && trs_en;

   anc_region_seq #(.DC_BITS(DC_BITS), .LEN_W(LEN_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .anc_go  (anc_go),
      .trs_go  (trs_go),
      .pkt_len (pkt_len),
      .rep     (rep),
      .ph      (ph),
      .busy    (busy)
   );

   logic [W-1:0] blank_word;
   always_comb begin
      if (comp_mode) blank_word = W'(BLK_COMP);
      else if (ph)   blank_word = W'(BLK_LUMA);
      else           blank_word = W'(BLK_CHROM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   dout <= '0;
      else if (rep) dout <= blank_word;
      else          dout <= oldest;
   end

   // R1: with both removal paths off and no region running, the word leaves untouched
   assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!del_en && !trs_en && !busy) |=> (dout == $past(oldest)));

   // R5: an EDH header outside a running region is forwarded
   assert_edh_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (anc_start && is_edh && !busy) |=> (dout == $past(oldest)));

   // R6: every replaced word is one of the blanking levels
   assert_blank_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rep |=> ((dout == W'(BLK_COMP)) || (dout == W'(BLK_LUMA)) || (dout == W'(BLK_CHROM))));

   // R8: in component mode a timing reference is forwarded
   assert_comp_trs_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trs_start && !comp_mode && !busy) |=> (dout == $past(oldest)));

endmodule

// File: tb/sim_anc_pkt_filter.sv
`timescale 1ns/1ps
module sim_anc_pkt_filter;

   localparam int W   = 10;
   localparam int NID = 4;
   localparam logic [9:0] IDLE  = 10'h080;
   localparam logic [7:0] D_AUD = 8'hE7;
   localparam logic [7:0] D_EXT = 8'hE6;
   localparam logic [7:0] D_ARB = 8'hC0;
   localparam logic [7:0] D_CTL = 8'hE3;
   localparam logic [7:0] D_OTH = 8'h45;
   localparam logic [7:0] D_EDH = 8'hF4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          comp_mode, anc_del_pin, trs_del_pin, reg_sel, reg_del, reg_trs;
   logic [NID*8-1:0] id_table;
   logic [W-1:0]  din, dout;

   anc_pkt_filter #(.W(W), .NUM_IDS(NID)) u0 (
      .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode),
      .anc_del_pin(anc_del_pin), .trs_del_pin(trs_del_pin),
      .reg_sel(reg_sel), .reg_del(reg_del), .reg_trs(reg_trs),
      .id_table(id_table), .din(din), .dout(dout)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   logic [9:0] in_q[$];
   logic [9:0] exp_q[$];

   task automatic chk(input string tag, input int idx, input logic [9:0] got, input logic [9:0] want);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s word %0d: actual %h expected %h", tag, idx, got, want);
      end
   endtask

   task automatic cfg(input bit comp, input bit pin, input bit tpin, input bit sel, input bit del, input bit trs);
      comp_mode = comp; anc_del_pin = pin; trs_del_pin = tpin;
      reg_sel = sel; reg_del = del; reg_trs = trs;
   endtask

   function automatic logic [9:0] blank_w(input int k, input bit comp);
      if (comp) return 10'h100;
      return (k % 2 == 0) ? 10'h200 : 10'h040;
   endfunction

   task automatic push_idle(input int cnt);
      for (int i = 0; i < cnt; i++) begin in_q.push_back(IDLE); exp_q.push_back(IDLE); end
   endtask

   task automatic push_pkt(input logic [7:0] id, input int n, input bit kill, input bit comp);
      logic [9:0] w[$];
      w.push_back(10'h000); w.push_back(10'h3FF); w.push_back(10'h3FF);
      w.push_back({2'b01, id});
      w.push_back(10'h180);
      w.push_back(10'h200 | 10'(n));
      for (int k = 0; k < n; k++) w.push_back(10'h100 + 10'(k));
      w.push_back(10'h155);
      for (int k = 0; k < w.size(); k++) begin
         in_q.push_back(w[k]);
         exp_q.push_back(kill ? blank_w(k, comp) : w[k]);
      end
   endtask

   task automatic push_trs(input bit kill, input bit comp);
      logic [9:0] w[4];
      w = '{10'h3FF, 10'h000, 10'h000, 10'h274};
      for (int k = 0; k < 4; k++) begin
         in_q.push_back(w[k]);
         exp_q.push_back(kill ? blank_w(k, comp) : w[k]);
      end
   endtask

   // drives the built stream, compares each output word 7 edges later
   task automatic run(input string tag, input int flip_at);
      int sz;
      sz = in_q.size();
      for (int n = 0; n < sz + 7; n++) begin
         @(negedge clk);
         if (n >= 7) chk(tag, n - 7, dout, exp_q[n-7]);
         if (n == flip_at) anc_del_pin = ~anc_del_pin;
         din = (n < sz) ? in_q[n] : IDLE;
      end
      in_q.delete();
      exp_q.delete();
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R11 reset output", 0, dout, 10'h000);
   endtask

   task automatic t_passthru;
      cfg(1, 0, 0, 0, 0, 0);
      push_idle(2); push_pkt(D_AUD, 4, 0, 1); push_trs(0, 1); push_idle(1);
      for (int k = 0; k < 6; k++) begin in_q.push_back(10'h010 + 10'(k*37)); exp_q.push_back(10'h010 + 10'(k*37)); end
      run("R1 pass-through latency", -1);
      cfg(1, 0, 0, 1, 0, 0);
      push_pkt(D_EXT, 3, 0, 1); push_trs(0, 1); push_idle(2);
      run("R2 select bit alone", -1);
      cfg(1, 0, 0, 0, 1, 1);
      push_pkt(D_ARB, 3, 0, 1); push_trs(0, 1); push_idle(2);
      run("R2 delete bit without select", -1);
   endtask

   task automatic t_pin_delete;
      cfg(0, 1, 0, 0, 0, 0);
      push_idle(3); push_pkt(D_AUD, 5, 1, 0); push_idle(4);
      run("R3 R6 pin delete component", -1);
   endtask

   task automatic t_reg_delete;
      cfg(1, 0, 0, 1, 1, 0);
      push_idle(2); push_pkt(D_EXT, 2, 1, 1); push_idle(1);
      push_pkt(D_ARB, 6, 1, 1); push_idle(1);
      push_pkt(D_CTL, 1, 1, 1); push_idle(3);
      run("R2 R3 R6 register delete composite", -1);
   endtask

   task automatic t_nomatch;
      cfg(0, 1, 0, 0, 0, 0);
      push_idle(2); push_pkt(D_OTH, 4, 0, 0); push_pkt(D_AUD, 3, 1, 0); push_idle(2);
      run("R4 unmatched identifier", -1);
   endtask

   task automatic t_edh;
      cfg(0, 1, 0, 1, 1, 0);
      id_table = {D_EDH, D_ARB, D_EXT, D_AUD};
      push_idle(2); push_pkt(D_EDH, 5, 0, 0); push_pkt(D_AUD, 2, 1, 0); push_idle(2);
      run("R5 EDH kept", -1);
      id_table = {D_CTL, D_ARB, D_EXT, D_AUD};
   endtask

   task automatic t_back2back;
      cfg(0, 1, 0, 0, 0, 0);
      push_idle(1);
      push_pkt(D_AUD, 3, 1, 0); push_pkt(D_CTL, 4, 1, 0);
      push_pkt(D_OTH, 2, 0, 0); push_pkt(D_EXT, 0, 1, 0);
      for (int k = 0; k < 5; k++) begin in_q.push_back(10'h123 + 10'(k)); exp_q.push_back(10'h123 + 10'(k)); end
      run("R9 adjacent packets", -1);
   endtask

   task automatic t_length;
      cfg(1, 1, 0, 0, 0, 0);
      push_idle(1); push_pkt(D_AUD, 0, 1, 1); push_pkt(D_ARB, 255, 1, 1); push_idle(3);
      run("R3 length extremes", -1);
   endtask

   task automatic t_trs_comp;
      cfg(1, 0, 1, 0, 0, 0);
      push_idle(2); push_trs(1, 1); push_idle(2); push_pkt(D_AUD, 2, 0, 1); push_idle(1);
      run("R7 TRS pin composite", -1);
      cfg(1, 0, 0, 1, 0, 1);
      push_idle(1); push_trs(1, 1); push_trs(1, 1); push_idle(2);
      run("R7 TRS register composite", -1);
   endtask

   task automatic t_trs_component;
      cfg(0, 0, 1, 1, 0, 1);
      push_idle(2); push_trs(0, 0); push_idle(2);
      run("R8 TRS kept in component", -1);
   endtask

   task automatic t_mid_change;
      cfg(0, 1, 0, 0, 0, 0);
      // packet header at index 2 judged long before the pin drops at index 12
      push_idle(2); push_pkt(D_AUD, 10, 1, 0); push_pkt(D_AUD, 2, 0, 0); push_idle(2);
      run("R10 control change after header", 12);
   endtask

   initial begin
      cfg(0, 0, 0, 0, 0, 0);
      id_table = {D_CTL, D_ARB, D_EXT, D_AUD};
      din = IDLE;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 output in reset", 0, dout, 10'h000);
      rst_n = 1'b1;
      t_reset();
      t_passthru();
      t_pin_delete();
      t_reg_delete();
      t_nomatch();
      t_edh();
      t_back2back();
      t_length();
      t_trs_comp();
      t_trs_component();
      t_mid_change();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule